// File: doc/BRIEF.md
# Private Memory Bus Master Sequencer

This block sits on the processor side of a private point-to-point memory path and runs cycles on it for a host. The host offers one request at a time over a request/acknowledge port. The request carries one of four kinds: plain read, read-pause, word write or byte write. It also carries an address, an I/O-page flag, write data and a code that says who used the shared general bus last. The sequencer first waits until the shared bus may be claimed. It then drives the address phase, including a two-bit cycle-type pair. At the end of that phase it checks the slave-select line from memory.

If memory has answered, a read runs as a burst with no handshake. The first word is taken on the trailing edge of the memory's read strobe. The second word is taken a fixed number of clocks later, and the bus-cycle line then drops. A write drives data, pulses the write strobe and releases bus-cycle one clock after the strobe ends. If slave-select is absent, no private cycle runs and the host is told that a general-bus cycle is needed. Both read words come back to the host with a parity result for each word.

A read-pause locks the sequencer. Until a write to the same address has completed, any other request is refused without bus activity.

Top module: `privmem_master`

## Requirements
- R1: After reset, bus_cyc, bus_wstb, bus_addr_oe, bus_wdata_oe and host_ack are all low.
- R2: During the address phase (bus_addr_oe high, bus_cyc low) bus_addr and bus_iopage show the request and the type pair is bus_wtbt = req_kind[1], bus_pbyt = req_kind[0]. The kind codes are 00 read, 01 read-pause, 10 word write and 11 byte write. The address stays stable while bus_addr_oe is high.
- R3: With hist code 1 (own general-bus cycle last) or 3 (other master last), the address phase does not begin while sync_in is high. With hist code 0 (none) or 2 (own interrupt service), sync_in is ignored. The address phase begins in the clock after the gate opens.
- R4: The address phase never begins while reply_in or bfull_in is high.
- R5: The address phase lasts exactly SETUP_CYC clocks. If sel_in is low at its last clock, bus_cyc is never raised and host_ack pulses with host_fallback high.
- R6: On a read, word 0 is the bus_rdata value at the first clock with rd_stb low after a clock with it high. Word 1 is the value SECOND_DLY clocks later. bus_cyc falls and host_ack pulses in the clock after word 1 is taken.
- R7: rd_perr[i] is set for word i when the high byte with par_hi does not have odd parity, or when the low byte with par_lo does not have even parity.
- R8: On a write, bus_cyc rises with bus_wdata_oe high and bus_wstb low. bus_wstb is then high for WSTB_CYC clocks. One more clock follows with bus_cyc high and bus_wstb low, then bus_cyc falls and host_ack pulses.
- R9: After a successful read-pause, a request that is not a write (kind 1x) to the same address is acknowledged at once with host_reject high and no bus activity. The lock ends only when a write to that address finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present; held until host_ack |
| req_kind | input | 2 | 00 read, 01 read-pause, 10 word write, 11 byte write |
| req_addr | input | AW | Target address |
| req_iopage | input | 1 | Address lies in the I/O page |
| req_wdata | input | DW | Write data |
| req_hist | input | 2 | Last bus user: 0 none, 1 own general, 2 own interrupt, 3 other master |
| host_ack | output | 1 | One-clock completion pulse |
| host_fallback | output | 1 | With host_ack: slave-select absent, general-bus cycle needed |
| host_reject | output | 1 | With host_ack: refused by read-pause lock |
| rd_word0 | output | DW | First read word |
| rd_word1 | output | DW | Second read word |
| rd_perr | output | 2 | Per-word parity error |
| sync_in | input | 1 | Received general-bus sync |
| reply_in | input | 1 | Received general-bus reply |
| bfull_in | input | 1 | Memory write buffer full |
| sel_in | input | 1 | Memory slave-select |
| bus_addr | output | AW | Address lines |
| bus_addr_oe | output | 1 | Address lines driven |
| bus_iopage | output | 1 | I/O-page flag |
| bus_wtbt | output | 1 | Cycle-type write flag |
| bus_pbyt | output | 1 | Cycle-type byte/pause flag |
| bus_cyc | output | 1 | Private bus-cycle |
| bus_wdata | output | DW | Write data lines |
| bus_wdata_oe | output | 1 | Write data driven |
| bus_wstb | output | 1 | Write strobe |
| rd_stb | input | 1 | Memory read strobe |
| bus_rdata | input | DW | Read data lines |
| par_hi | input | 1 | High-byte parity bit |
| par_lo | input | 1 | Low-byte parity bit |

## Verification
Read data is valid on the lines only at the clock of the strobe's trailing edge and at the clock exactly SECOND_DLY later. Junk is driven at every other clock. A sequencer that samples one clock early or late, or that drops bus-cycle before the second word, returns the wrong word or acknowledges at the wrong clock. Each gating code is held against a sync or reply that is still high for several clocks, and then released. A sequencer that mixes up the history codes either starts too early or hangs. The lock is tested with a read and with a write to another address, both of which must be refused. The matching write must then go through. A missing slave-select and single-byte parity faults in each word cover the fallback path and the per-word error bits.

// File: rtl/privmem_pkg.sv
package privmem_pkg;

   typedef enum logic [1:0] {
      K_READ   = 2'b00,
      K_RPAUSE = 2'b01,
      K_WWORD  = 2'b10,
      K_WBYTE  = 2'b11
   } kind_e;

   typedef enum logic [1:0] {
      H_NONE     = 2'd0,
      H_OWN_GEN  = 2'd1,
      H_OWN_INTR = 2'd2,
      H_OTHER    = 2'd3
   } hist_e;

   typedef enum logic [3:0] {
      S_IDLE, S_GAP, S_ADDR, S_RD_WAIT, S_RD_DLY,
      S_WR_DATA, S_WR_STB, S_WR_END, S_DONE
   } state_e;

   typedef enum logic [1:0] {
      RES_OK, RES_FALLBACK, RES_REJECT
   } result_e;

   // high half must carry odd parity together with its bit
   function automatic logic hi_par_bad(input logic [7:0] b, input logic p);
      return ~(^{b, p});
   endfunction

   // low half must carry even parity together with its bit
   function automatic logic lo_par_bad(input logic [7:0] b, input logic p);
      return ^{b, p};
   endfunction

endpackage

// File: rtl/privmem_gap.sv
module privmem_gap
   import privmem_pkg::*;
(
   input  logic [1:0] hist,
   input  logic       sync_in,
   input  logic       reply_in,
   input  logic       bfull_in,
   output logic       clear
);
   logic need_sync_low;

   always_comb begin
      unique case (hist_e'(hist))
         H_OWN_GEN: need_sync_low = 1'b1;
         H_OTHER:   need_sync_low = 1'b1;
         default:   need_sync_low = 1'b0;
      endcase
      clear = !reply_in && !bfull_in && !(need_sync_low && sync_in);
   end

endmodule

// File: rtl/privmem_lock.sv
module privmem_lock #(
   parameter int AW = 22
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_i,
   input  logic          clr_i,
   input  logic [AW-1:0] set_addr,
   input  logic [1:0]    chk_kind,
   input  logic [AW-1:0] chk_addr,
   output logic          violate
);
   logic          lock_q;
   logic [AW-1:0] lock_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q      <= 1'b0;
         lock_addr_q <= '0;
      end else if (set_i) begin
         lock_q      <= 1'b1;
         lock_addr_q <= set_addr;
      end else if (clr_i) begin
         lock_q      <= 1'b0;
      end
   end

   assign violate = lock_q && (!chk_kind[1] || (chk_addr != lock_addr_q));

endmodule

// File: rtl/privmem_rdcap.sv
module privmem_rdcap
   import privmem_pkg::*;
#(
   parameter int DW         = 16,
   parameter int SECOND_DLY = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          rd_stb,
   input  logic [DW-1:0] bus_rdata,
   input  logic          par_hi,
   input  logic          par_lo,
   output logic          got_first,
   output logic          got_second,
   output logic [DW-1:0] word0,
   output logic [DW-1:0] word1,
   output logic [1:0]    perr
);
   localparam int HALF = DW / 2;
   localparam int CW   = $clog2(SECOND_DLY + 1);

   logic          stb_q;
   logic          run_q;
   logic [CW-1:0] cnt_q;
   logic [1:0]    cap;
   logic          bad_now;
   logic [DW-1:0] word_q [2];

   assign got_first  = arm && stb_q && !rd_stb;
   assign got_second = run_q && (cnt_q == '0);
   assign cap        = {got_second, got_first};
   assign bad_now    = hi_par_bad(bus_rdata[DW-1 -: 8], par_hi)
                     | lo_par_bad(bus_rdata[HALF-1 -: 8], par_lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_q <= 1'b0;
         run_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         stb_q <= rd_stb;
         if (got_first) begin
            run_q <= 1'b1;
            cnt_q <= CW'(SECOND_DLY - 1);
         end else if (got_second) begin
            run_q <= 1'b0;
         end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q[g] <= '0;
            perr[g]   <= 1'b0;
         end else if (cap[g]) begin
            word_q[g] <= bus_rdata;
            perr[g]   <= bad_now;
         end
      end
   end

   assign word0 = word_q[0];
   assign word1 = word_q[1];

endmodule

// File: rtl/privmem_master.sv
module privmem_master
   import privmem_pkg::*;
#(
   parameter int AW         = 22,
   parameter int DW         = 16,
   parameter int SETUP_CYC  = 2,
   parameter int SECOND_DLY = 3,
   parameter int WSTB_CYC   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_kind,
   input  logic [AW-1:0] req_addr,
   input  logic          req_iopage,
   input  logic [DW-1:0] req_wdata,
   input  logic [1:0]    req_hist,
   output logic          host_ack,
   output logic          host_fallback,
   output logic          host_reject,
   output logic [DW-1:0] rd_word0,
   output logic [DW-1:0] rd_word1,
   output logic [1:0]    rd_perr,
   input  logic          sync_in,
   input  logic          reply_in,
   input  logic          bfull_in,
   input  logic          sel_in,
   output logic [AW-1:0] bus_addr,
   output logic          bus_addr_oe,
   output logic          bus_iopage,
   output logic          bus_wtbt,
   output logic          bus_pbyt,
   output logic          bus_cyc,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_wdata_oe,
   output logic          bus_wstb,
   input  logic          rd_stb,
   input  logic [DW-1:0] bus_rdata,
   input  logic          par_hi,
   input  logic          par_lo
);
   localparam int MAXC = (SETUP_CYC > WSTB_CYC) ? SETUP_CYC : WSTB_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("SETUP_CYC must be at least 1");
   end
   if (SECOND_DLY < 1) begin : g_bad_dly
      $error("SECOND_DLY must be at least 1");
   end
   if (WSTB_CYC < 1) begin : g_bad_wstb
      $error("WSTB_CYC must be at least 1");
   end
   if (DW < 16 || (DW % 2) != 0) begin : g_bad_dw
      $error("DW must be even and at least 16");
   end

   state_e        state_q;
   result_e       res_q;
   logic [CW-1:0] cnt_q;
   logic [1:0]    kind_q;
   logic [1:0]    hist_q;
   logic [AW-1:0] addr_q;
   logic          io_q;
   logic [DW-1:0] wdata_q;

   logic gap_clear, lock_violate, got_first, got_second;
   logic lock_set, lock_clr, addr_last;

   privmem_gap u_gap (
      .hist     (hist_q),
      .sync_in  (sync_in),
      .reply_in (reply_in),
      .bfull_in (bfull_in),
      .clear    (gap_clear)
   );

   assign addr_last = (state_q == S_ADDR) && (cnt_q == '0);
   assign lock_set  = (state_q == S_RD_DLY) && got_second && (kind_e'(kind_q) == K_RPAUSE);
   assign lock_clr  = (state_q == S_WR_END) || (addr_last && !sel_in && kind_q[1]);

   privmem_lock #(.AW(AW)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (lock_set),
      .clr_i    (lock_clr),
      .set_addr (addr_q),
      .chk_kind (req_kind),
      .chk_addr (req_addr),
      .violate  (lock_violate)
   );

   privmem_rdcap #(.DW(DW), .SECOND_DLY(SECOND_DLY)) u_rdcap (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (state_q == S_RD_WAIT),
      .rd_stb     (rd_stb),
      .bus_rdata  (bus_rdata),
      .par_hi     (par_hi),
      .par_lo     (par_lo),
      .got_first  (got_first),
      .got_second (got_second),
      .word0      (rd_word0),
      .word1      (rd_word1),
      .perr       (rd_perr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         res_q   <= RES_OK;
         cnt_q   <= '0;
         kind_q  <= '0;
         hist_q  <= '0;
         addr_q  <= '0;
         io_q    <= 1'b0;
         wdata_q <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: if (req_valid) begin
               kind_q  <= req_kind;
               hist_q  <= req_hist;
               addr_q  <= req_addr;
               io_q    <= req_iopage;
               wdata_q <= req_wdata;
               if (lock_violate) begin
                  res_q   <= RES_REJECT;
                  state_q <= S_DONE;
               end else begin
                  state_q <= S_GAP;
               end
            end
            S_GAP: if (gap_clear) begin
               cnt_q   <= CW'(SETUP_CYC - 1);
               state_q <= S_ADDR;
            end
            S_ADDR: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (!sel_in) begin
                  res_q   <= RES_FALLBACK;
                  state_q <= S_DONE;
               end else begin
                  res_q   <= RES_OK;
                  state_q <= kind_q[1] ? S_WR_DATA : S_RD_WAIT;
               end
            end
            S_RD_WAIT: if (got_first)  state_q <= S_RD_DLY;
            S_RD_DLY:  if (got_second) state_q <= S_DONE;
            S_WR_DATA: begin
               cnt_q   <= CW'(WSTB_CYC - 1);
               state_q <= S_WR_STB;
            end
            S_WR_STB: begin
               if (cnt_q != '0) cnt_q   <= cnt_q - 1'b1;
               else             state_q <= S_WR_END;
            end
            S_WR_END: state_q <= S_DONE;
            S_DONE:   state_q <= S_IDLE;
            default:  state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_cyc      = 1'b0;
      bus_wdata_oe = 1'b0;
      unique case (state_q)
         S_RD_WAIT, S_RD_DLY: bus_cyc = 1'b1;
         S_WR_DATA, S_WR_STB, S_WR_END: begin
            bus_cyc      = 1'b1;
            bus_wdata_oe = 1'b1;
         end
         default: ;
      endcase
   end

   assign bus_addr_oe   = (state_q == S_ADDR) || bus_cyc;
   assign bus_addr      = addr_q;
   assign bus_iopage    = bus_addr_oe && io_q;
   assign bus_wtbt      = (state_q == S_ADDR) && kind_q[1];
   assign bus_pbyt      = (state_q == S_ADDR) && kind_q[0];
   assign bus_wdata     = wdata_q;
   assign bus_wstb      = (state_q == S_WR_STB);
   assign host_ack      = (state_q == S_DONE);
   assign host_fallback = host_ack && (res_q == RES_FALLBACK);
   assign host_reject   = host_ack && (res_q == RES_REJECT);

endmodule

// File: rtl/privmem_master_chk.sv
module privmem_master_chk #(
   parameter int AW = 22
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel_in,
   input logic          bfull_in,
   input logic          reply_in,
   input logic [AW-1:0] bus_addr,
   input logic          bus_addr_oe,
   input logic          bus_cyc,
   input logic          bus_wstb,
   input logic          bus_wdata_oe,
   input logic          host_ack,
   input logic          host_fallback,
   input logic          host_reject
);

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !bus_cyc && !host_ack && !bus_wstb);

   assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_oe && $past(bus_addr_oe) |-> $stable(bus_addr));

   assert_start_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_addr_oe) |-> $past(!bfull_in && !reply_in));

   assert_cyc_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_cyc) |-> $past(sel_in));

   assert_fallback_no_cyc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      host_fallback |-> !bus_cyc && !$past(bus_cyc));

   assert_cyc_end_acks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_cyc) |-> host_ack);

   assert_wstb_in_cyc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wstb |-> bus_cyc && bus_wdata_oe);

   assert_cyc_after_wstb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_wstb) |-> bus_cyc);

   assert_reject_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      host_reject |-> !bus_addr_oe && !$past(bus_addr_oe));

   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({host_fallback, host_reject}) && ((host_fallback || host_reject) -> host_ack));

endmodule

bind privmem_master privmem_master_chk #(.AW(AW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sel_in        (sel_in),
   .bfull_in      (bfull_in),
   .reply_in      (reply_in),
   .bus_addr      (bus_addr),
   .bus_addr_oe   (bus_addr_oe),
   .bus_cyc       (bus_cyc),
   .bus_wstb      (bus_wstb),
   .bus_wdata_oe  (bus_wdata_oe),
   .host_ack      (host_ack),
   .host_fallback (host_fallback),
   .host_reject   (host_reject)
);

// File: tb/privmem_master_tb.sv
module privmem_master_tb;
   localparam int AW = 22, DW = 16, SU = 2, SD = 3, WS = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_iopage = 0, sync_in = 0, reply_in = 0, bfull_in = 0, sel_in = 1;
   logic [1:0] req_kind = 0, req_hist = 0;
   logic [AW-1:0] req_addr = 0;
   logic [DW-1:0] req_wdata = 0, bus_rdata = 0;
   logic rd_stb = 0, par_hi = 0, par_lo = 0;
   logic host_ack, host_fallback, host_reject, bus_addr_oe, bus_iopage, bus_wtbt, bus_pbyt;
   logic bus_cyc, bus_wdata_oe, bus_wstb;
   logic [DW-1:0] rd_word0, rd_word1, bus_wdata;
   logic [1:0] rd_perr;
   logic [AW-1:0] bus_addr;
   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   privmem_master #(.AW(AW), .DW(DW), .SETUP_CYC(SU), .SECOND_DLY(SD), .WSTB_CYC(WS)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_iopage(req_iopage), .req_wdata(req_wdata), .req_hist(req_hist), .host_ack(host_ack),
      .host_fallback(host_fallback), .host_reject(host_reject), .rd_word0(rd_word0),
      .rd_word1(rd_word1), .rd_perr(rd_perr), .sync_in(sync_in), .reply_in(reply_in),
      .bfull_in(bfull_in), .sel_in(sel_in), .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe),
      .bus_iopage(bus_iopage), .bus_wtbt(bus_wtbt), .bus_pbyt(bus_pbyt), .bus_cyc(bus_cyc),
      .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_wstb(bus_wstb), .rd_stb(rd_stb),
      .bus_rdata(bus_rdata), .par_hi(par_hi), .par_lo(par_lo));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // drive a word with its parity bits, optionally corrupted
   task automatic put_word(input logic [15:0] w, input logic flip_hi, input logic flip_lo);
      bus_rdata = w;
      par_hi = (~^w[15:8]) ^ flip_hi;
      par_lo = (^w[7:0]) ^ flip_lo;
   endtask

   task automatic issue(input logic [1:0] k, input logic [AW-1:0] a, input logic io,
                        input logic [15:0] wd, input logic [1:0] h);
      req_kind = k; req_addr = a; req_iopage = io; req_wdata = wd; req_hist = h;
      req_valid = 1'b1;
   endtask

   // wait for address phase, check its contents and its length
   task automatic addr_phase(input logic [1:0] k, input logic [AW-1:0] a, input logic io);
      int n = 0;
      while (!bus_addr_oe && n < 40) begin tick(); n++; end
      check("R3 address phase started", 32'(bus_addr_oe), 1);
      for (int j = 0; j < SU; j++) begin
         check("R5 addr phase length", 32'({bus_addr_oe, bus_cyc}), 32'b10);
         check("R2 type pair", 32'({bus_wtbt, bus_pbyt}), 32'(k));
         check("R2 address", 32'(bus_addr), 32'(a));
         check("R2 io page", 32'(bus_iopage), 32'(io));
         tick();
      end
   endtask

   task automatic do_read(input logic [15:0] w0, input logic [15:0] w1,
                          input logic [1:0] flip0, input logic [1:0] flip1,
                          input logic [1:0] exp_perr);
      check("R6 cyc raised for read", 32'(bus_cyc), 1);
      rd_stb = 1'b1; put_word(w0, flip0[1], flip0[0]);
      tick(); tick();
      rd_stb = 1'b0;          // trailing edge seen at the next clock
      tick();
      check("R6 cyc held after first word", 32'({bus_cyc, host_ack}), 32'b10);
      for (int j = 1; j <= SD; j++) begin
         if (j == SD) put_word(w1, flip1[1], flip1[0]);
         else         put_word(16'hDEAD ^ 16'(j), 1'b0, 1'b0);
         tick();
         if (j < SD) check("R6 cyc held until second word", 32'({bus_cyc, host_ack}), 32'b10);
      end
      check("R6 cyc drops with ack", 32'({bus_cyc, host_ack, host_fallback, host_reject}), 32'b0100);
      check("R6 word0", 32'(rd_word0), 32'(w0));
      check("R6 word1", 32'(rd_word1), 32'(w1));
      check("R7 parity flags", 32'(rd_perr), 32'(exp_perr));
      req_valid = 1'b0;
      put_word(16'h0, 1'b0, 1'b0);
      tick();
   endtask

   task automatic do_write(input logic [15:0] wd);
      check("R8 cyc with data, no strobe", 32'({bus_cyc, bus_wdata_oe, bus_wstb}), 32'b110);
      check("R8 write data", 32'(bus_wdata), 32'(wd));
      for (int j = 0; j < WS; j++) begin
         tick();
         check("R8 strobe width", 32'({bus_cyc, bus_wstb}), 32'b11);
      end
      tick();
      check("R8 strobe off, cyc held", 32'({bus_cyc, bus_wstb, bus_wdata_oe}), 32'b101);
      tick();
      check("R8 cyc drops with ack", 32'({bus_cyc, host_ack, host_fallback}), 32'b010);
      req_valid = 1'b0;
      tick();
   endtask

   // gate test: blocker held, then released
   task automatic blocked(input string req);
      for (int j = 0; j < 4; j++) begin
         tick();
         check(req, 32'(bus_addr_oe), 0);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick();
      check("R1 reset outputs", 32'({bus_cyc, bus_wstb, bus_addr_oe, bus_wdata_oe, host_ack}), 0);
      rst_n = 1'b1;
      tick();
      check("R1 idle after reset", 32'({bus_cyc, bus_wstb, bus_addr_oe, bus_wdata_oe, host_ack}), 0);

      // plain read, hist none ignores sync
      sync_in = 1'b1;
      issue(2'b00, 22'h01F3A2, 1'b0, 16'h0, 2'd0);
      tick(); tick();
      check("R3 hist none ignores sync", 32'(bus_addr_oe), 1);
      addr_phase(2'b00, 22'h01F3A2, 1'b0);
      do_read(16'h1234, 16'hA5C3, 2'b00, 2'b00, 2'b00);

      // word write, interrupt history ignores sync but waits on reply
      reply_in = 1'b1;
      issue(2'b10, 22'h000444, 1'b1, 16'hBEEF, 2'd2);
      blocked("R4 reply blocks start");
      reply_in = 1'b0;
      tick();
      check("R3 start after gate opens", 32'(bus_addr_oe), 1);
      addr_phase(2'b10, 22'h000444, 1'b1);
      do_write(16'hBEEF);

      // byte write while buffer full
      sync_in = 1'b0; bfull_in = 1'b1;
      issue(2'b11, 22'h000445, 1'b0, 16'h00C1, 2'd0);
      blocked("R4 buffer full blocks start");
      bfull_in = 1'b0;
      tick();
      check("R4 start after buffer drains", 32'(bus_addr_oe), 1);
      addr_phase(2'b11, 22'h000445, 1'b0);
      do_write(16'h00C1);

      // own general history waits on sync; word1 high-byte parity bad
      sync_in = 1'b1;
      issue(2'b00, 22'h2AAAAA, 1'b0, 16'h0, 2'd1);
      blocked("R3 own general waits on sync");
      sync_in = 1'b0;
      tick();
      check("R3 own general starts after sync", 32'(bus_addr_oe), 1);
      addr_phase(2'b00, 22'h2AAAAA, 1'b0);
      do_read(16'h0F0F, 16'hFF00, 2'b00, 2'b10, 2'b10);

      // other master waits on sync; read-pause sets the lock; word0 low-byte bad
      sync_in = 1'b1;
      issue(2'b01, 22'h001000, 1'b0, 16'h0, 2'd3);
      blocked("R3 other master waits on sync");
      sync_in = 1'b0;
      tick();
      check("R3 other master starts after sync", 32'(bus_addr_oe), 1);
      addr_phase(2'b01, 22'h001000, 1'b0);
      do_read(16'h8001, 16'h7FFE, 2'b01, 2'b00, 2'b01);

      // lock: read refused
      issue(2'b00, 22'h001000, 1'b0, 16'h0, 2'd0);
      tick();
      check("R9 read refused after pause", 32'({host_ack, host_reject, bus_addr_oe}), 32'b110);
      req_valid = 1'b0; tick();
      // lock: write to other address refused
      issue(2'b10, 22'h001002, 1'b0, 16'h1111, 2'd0);
      tick();
      check("R9 other-address write refused", 32'({host_ack, host_reject, bus_addr_oe}), 32'b110);
      req_valid = 1'b0; tick();
      // matching write goes through
      issue(2'b10, 22'h001000, 1'b0, 16'h2222, 2'd0);
      tick();
      check("R9 matching write accepted", 32'(host_ack), 0);
      addr_phase(2'b10, 22'h001000, 1'b0);
      do_write(16'h2222);

      // lock cleared; no slave-select gives fallback
      sel_in = 1'b0;
      issue(2'b00, 22'h3F0000, 1'b1, 16'h0, 2'd0);
      addr_phase(2'b00, 22'h3F0000, 1'b1);
      check("R5 fallback ack, no cycle", 32'({host_ack, host_fallback, host_reject, bus_cyc}), 32'b1100);
      check("R9 lock cleared by write", 32'(host_reject), 0);
      req_valid = 1'b0; sel_in = 1'b1;
      tick();
      check("R5 idle after fallback", 32'({bus_cyc, bus_addr_oe, host_ack}), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule